// File: doc/BRIEF.md
# Flag Threshold Loader for a Dual FIFO

This block owns the four threshold values that a pair of FIFOs compare against to raise their almost-empty and almost-full flags. Each FIFO has one almost-empty threshold and one almost-full threshold, so there are four values in all. Each value is log2(DEPTH) bits wide. Programming starts when master reset is released. A three-bit strap code is read during reset and picks one of three methods:

- a preset value copied into all four thresholds;
- four word writes on a parallel data path;
- a bit-serial stream on a data pin, qualified by an active-low enable pin and clocked by the write-side clock.

The two serial pins have a second job: during reset they also act as strap inputs. The block raises `done` once programming is complete. After that it holds the thresholds until the next master reset. A partial reset of the FIFOs does not touch them.

The controller is a four-state machine:

- **CFG** is held throughout reset. On the first clock after release it leaves: to **DONE** for a preset code, to **SERIAL** for a serial code, or to **PARALLEL** for the parallel code.
- **SERIAL** moves to **DONE** on the edge that takes the last bit.
- **PARALLEL** moves to **DONE** on the edge that takes the fourth word.
- **DONE** stays in **DONE** until master reset.

All four thresholds live in one shift chain of 4·W bits. A serial bit enters at the LSB end, and a parallel word enters the lowest W bits. In both cases the earlier contents move up.

Top module: `flag_ofs_loader`

## Requirements
- R1: While `mrst_n` is low at a rising edge, `done` is 0 and all four thresholds are 0. The strap code {`strap_hi`, `sen_n`, `sdat`} is captured at every such edge. The code held at the last edge before release selects the method, and later pin changes do not alter it.
- R2: Strap codes 0, 1, 2, 3 and 4 select preset values 8, 16, 64, 256 and 1024 (truncated to W bits). On the first rising edge after release, all four thresholds take the preset and `done` goes to 1.
- R3: Strap code 5 selects parallel loading. Codes 6 and 7 select serial loading.
- R4: In serial mode, starting from the second rising edge after release, each rising edge with `sen_n` low shifts `sdat` into the chain. An edge with `sen_n` high shifts nothing.
- R5: The serial stream is 4·W bits long. The first bit is the MSB of `ofs_ae1`. The stream then fills `ofs_ae1`, `ofs_af1`, `ofs_ae2` and `ofs_af2` in that order, each MSB first. The last bit is the LSB of `ofs_af2`.
- R6: `done` stays 0 until the rising edge that takes the 4·W-th serial bit, and it is 1 after that edge.
- R7: In parallel mode, starting from the second rising edge after release, each rising edge with `pl_we` high takes `pl_data` as the next threshold, in the order `ofs_ae1`, `ofs_af1`, `ofs_ae2`, `ofs_af2`. `done` goes to 1 on the edge that takes the fourth word.
- R8: Once `done` is 1, further serial bits and parallel writes change neither the thresholds nor `done`.
- R9: `prst_n` never changes the thresholds or `done`.
- R10: `pl_we` has no effect in serial mode, and `sen_n` has no effect in parallel mode.
- R11: A new master reset clears the thresholds and `done` and restarts programming with the newly strapped method.
- R12: Every threshold is W = log2(DEPTH) bits wide, so a serial load takes 4·log2(DEPTH) bits (44 bits for DEPTH 2048).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock; all state changes on its rising edge |
| mrst_n | input | 1 | Master reset, active low, synchronous |
| prst_n | input | 1 | FIFO partial reset, active low; leaves thresholds alone |
| strap_hi | input | 1 | Strap code bit 2, read only during reset |
| sen_n | input | 1 | Strap code bit 1 during reset; active-low serial enable afterwards |
| sdat | input | 1 | Strap code bit 0 during reset; serial data afterwards |
| pl_we | input | 1 | Parallel threshold write strobe |
| pl_data | input | W | Parallel threshold word |
| ofs_ae1 | output | W | FIFO 1 almost-empty threshold |
| ofs_af1 | output | W | FIFO 1 almost-full threshold |
| ofs_ae2 | output | W | FIFO 2 almost-empty threshold |
| ofs_af2 | output | W | FIFO 2 almost-full threshold |
| done | output | 1 | Programming complete |

## Verification
The risky coincidence is the closing serial edge landing in the same cycle as a partial-reset pulse and a parallel write strobe. That edge must shift exactly one bit, raise `done`, and ignore both other inputs. The bench drives that combination on the final bit of every serial pattern. It then compares each threshold against slices of the pattern it shifted. It also drives extra bits on the cycle right after `done` rises, to show that completion and a further enable do not overlap.

// File: rtl/flag_ofs_pkg.sv
package flag_ofs_pkg;

    typedef enum logic [1:0] {
        ST_CFG,
        ST_SERIAL,
        ST_PARALLEL,
        ST_DONE
    } ld_state_e;

    typedef enum logic [1:0] {
        LM_PRESET,
        LM_SERIAL,
        LM_PARALLEL
    } ld_mode_e;

    localparam int PRESET_W = 11;

    function automatic ld_mode_e strap_mode(input logic [2:0] code);
        if (code <= 3'd4)      return LM_PRESET;
        else if (code == 3'd5) return LM_PARALLEL;
        else                   return LM_SERIAL;
    endfunction

    function automatic logic [PRESET_W-1:0] strap_preset(input logic [2:0] code);
        case (code)
            3'd0:    return PRESET_W'(8);
            3'd1:    return PRESET_W'(16);
            3'd2:    return PRESET_W'(64);
            3'd3:    return PRESET_W'(256);
            default: return PRESET_W'(1024);
        endcase
    endfunction

endpackage

// File: rtl/ofs_strap_latch.sv
module ofs_strap_latch
    import flag_ofs_pkg::*;
(
    input  logic                clk,
    input  logic                mrst_n,
    input  logic [2:0]          strap,
    output ld_mode_e            mode_q,
    output logic [PRESET_W-1:0] preset_q
);

    // Captured on every edge while reset is held; frozen after release.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            mode_q   <= strap_mode(strap);
            preset_q <= strap_preset(strap);
        end
    end

    // R1: after release the method choice does not move
    a_r1_strap_frozen: assert property (@(posedge clk) disable iff (!mrst_n)
        mrst_n |=> ($stable(mode_q) && $stable(preset_q)));

endmodule

// File: rtl/ofs_unit_cnt.sv
module ofs_unit_cnt #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          inc,
    input  logic [CW-1:0] limit,
    output logic          last
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clr)
            cnt_q <= '0;
        else if (inc && cnt_q != limit)
            cnt_q <= cnt_q + CW'(1);
    end

    assign last = (cnt_q == limit - CW'(1));

    // R6: unit count never runs past the programmed length
    a_r6_cnt_bounded: assert property (@(posedge clk) disable iff (clr)
        cnt_q <= limit);

endmodule

// File: rtl/ofs_chain.sv
module ofs_chain
    import flag_ofs_pkg::*;
#(
    parameter int W = 11,
    localparam int CHAIN_W = 4 * W
) (
    input  logic               clk,
    input  logic               mrst_n,
    input  logic               load_all,
    input  logic [W-1:0]       preset_w,
    input  logic               word_en,
    input  logic [W-1:0]       word_in,
    input  logic               bit_en,
    input  logic               bit_in,
    output logic [CHAIN_W-1:0] chain_q
);

    always_ff @(posedge clk) begin
        if (!mrst_n)
            chain_q <= '0;
        else if (load_all)
            chain_q <= {4{preset_w}};
        else if (word_en)
            chain_q <= {chain_q[CHAIN_W-W-1:0], word_in};
        else if (bit_en)
            chain_q <= {chain_q[CHAIN_W-2:0], bit_in};
    end

    // R4: an accepted serial bit lands at the chain's LSB
    a_r4_bit_enters_lsb: assert property (@(posedge clk) disable iff (!mrst_n)
        (bit_en && !word_en && !load_all) |=> (chain_q[0] == $past(bit_in)));

    // R7: an accepted word lands in the lowest threshold slot
    a_r7_word_enters_low: assert property (@(posedge clk) disable iff (!mrst_n)
        (word_en && !load_all) |=> (chain_q[W-1:0] == $past(word_in)));

endmodule

// File: rtl/flag_ofs_loader.sv
module flag_ofs_loader
    import flag_ofs_pkg::*;
#(
    parameter int  DEPTH = 4096,
    localparam int W     = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         mrst_n,
    input  logic         prst_n,
    input  logic         strap_hi,
    input  logic         sen_n,
    input  logic         sdat,
    input  logic         pl_we,
    input  logic [W-1:0] pl_data,
    output logic [W-1:0] ofs_ae1,
    output logic [W-1:0] ofs_af1,
    output logic [W-1:0] ofs_ae2,
    output logic [W-1:0] ofs_af2,
    output logic         done
);

    localparam int CHAIN_W = 4 * W;
    localparam int CW      = $clog2(CHAIN_W + 1);

    ld_state_e            state_q, state_d;
    ld_mode_e             mode_q;
    logic [PRESET_W-1:0]  preset_q;
    logic [CHAIN_W-1:0]   chain_q;
    logic [CW-1:0]        limit;
    logic                 last;
    logic                 bit_take, word_take, load_preset;

    ofs_strap_latch u_strap (
        .clk      (clk),
        .mrst_n   (mrst_n),
        .strap    ({strap_hi, sen_n, sdat}),
        .mode_q   (mode_q),
        .preset_q (preset_q)
    );

    assign limit = (mode_q == LM_SERIAL) ? CW'(CHAIN_W) : CW'(4);

    ofs_unit_cnt #(.CW(CW)) u_cnt (
        .clk   (clk),
        .clr   (!mrst_n),
        .inc   (bit_take || word_take),
        .limit (limit),
        .last  (last)
    );

    ofs_chain #(.W(W)) u_chain (
        .clk      (clk),
        .mrst_n   (mrst_n),
        .load_all (load_preset),
        .preset_w (W'(preset_q)),
        .word_en  (word_take),
        .word_in  (pl_data),
        .bit_en   (bit_take),
        .bit_in   (sdat),
        .chain_q  (chain_q)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!mrst_n)
            state_q <= ST_CFG;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CFG: begin
                unique case (mode_q)
                    LM_PRESET:   state_d = ST_DONE;
                    LM_SERIAL:   state_d = ST_SERIAL;
                    LM_PARALLEL: state_d = ST_PARALLEL;
                    default:     state_d = ST_CFG;
                endcase
            end
            ST_SERIAL:   if (bit_take && last)  state_d = ST_DONE;
            ST_PARALLEL: if (word_take && last) state_d = ST_DONE;
            ST_DONE:     state_d = ST_DONE;
            default:     state_d = ST_CFG;
        endcase
    end

    // Outputs and datapath strobes
    always_comb begin
        bit_take    = (state_q == ST_SERIAL)   && !sen_n;
        word_take   = (state_q == ST_PARALLEL) && pl_we;
        load_preset = (state_q == ST_CFG)      && (mode_q == LM_PRESET);
        done        = (state_q == ST_DONE);
    end

    assign ofs_ae1 = chain_q[4*W-1 -: W];
    assign ofs_af1 = chain_q[3*W-1 -: W];
    assign ofs_ae2 = chain_q[2*W-1 -: W];
    assign ofs_af2 = chain_q[W-1:0];

    // R8: done is sticky until master reset
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!mrst_n)
        done |=> done);

    // R8: thresholds frozen once programming completes
    a_r8_ofs_frozen: assert property (@(posedge clk) disable iff (!mrst_n)
        done |=> $stable(chain_q));

    // R9: partial reset leaves completed thresholds alone
    a_r9_prst_ignored: assert property (@(posedge clk) disable iff (!mrst_n)
        (done && !prst_n) |=> ($stable(ofs_ae1) && $stable(ofs_af2) && done));

    // R2: a preset method completes in one edge with four equal thresholds
    a_r2_preset_fill: assert property (@(posedge clk) disable iff (!mrst_n)
        (state_q == ST_CFG && mode_q == LM_PRESET) |=>
            (done && ofs_ae1 == ofs_af1 && ofs_ae2 == ofs_af2 && ofs_ae1 == ofs_af2));

    // R1: nothing is complete while reset is held
    a_r1_reset_idle: assert property (@(posedge clk)
        !mrst_n |=> (!mrst_n || !done));

endmodule

// File: tb/sim_flag_ofs_loader.sv
module sim_flag_ofs_loader;

    localparam int DEPTH = 2048;
    localparam int W     = 11;
    localparam int NB    = 4 * W;

    logic         clk = 1'b0;
    logic         mrst_n = 1'b0, prst_n = 1'b1;
    logic         strap_hi = 1'b0, sen_n = 1'b1, sdat = 1'b0;
    logic         pl_we = 1'b0;
    logic [W-1:0] pl_data = '0;
    logic [W-1:0] ofs_ae1, ofs_af1, ofs_ae2, ofs_af2;
    logic         done;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    flag_ofs_loader #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .strap_hi(strap_hi),
        .sen_n(sen_n), .sdat(sdat), .pl_we(pl_we), .pl_data(pl_data),
        .ofs_ae1(ofs_ae1), .ofs_af1(ofs_af1), .ofs_ae2(ofs_ae2), .ofs_af2(ofs_af2),
        .done(done)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_regs(input string req, input logic [NB-1:0] v);
        check({req, " ae1"}, 64'(ofs_ae1), 64'(v[4*W-1 -: W]));
        check({req, " af1"}, 64'(ofs_af1), 64'(v[3*W-1 -: W]));
        check({req, " ae2"}, 64'(ofs_ae2), 64'(v[2*W-1 -: W]));
        check({req, " af2"}, 64'(ofs_af2), 64'(v[W-1:0]));
    endtask

    // Hold reset with a strap code, check the idle state, release.
    task automatic master_reset(input logic [2:0] code);
        {strap_hi, sen_n, sdat} = code;
        pl_we  = 1'b0;
        mrst_n = 1'b0;
        tick();
        tick();
        check("R1 done in reset", 64'(done), 64'd0);
        check_regs("R1 cleared", '0);
        mrst_n = 1'b1;
        strap_hi = ~code[2];
        sen_n = 1'b1;
        sdat = ~code[0];
        check("R1 done at release", 64'(done), 64'd0);
    endtask

    // R4 R5 R6 R9 R10: shift a full pattern, optionally with idle gaps.
    task automatic serial_load(input logic [NB-1:0] v, input bit gaps);
        for (int i = 0; i < NB; i++) begin
            if (gaps && (i % 5 == 2)) begin
                sen_n = 1'b1;
                sdat = ~v[NB-1-i];
                tick();
            end
            sen_n   = 1'b0;
            sdat    = v[NB-1-i];
            pl_we   = (i % 7 == 3) || (i == NB - 1);
            pl_data = W'(i * 37 + 5);
            prst_n  = (i == NB - 1) ? 1'b0 : 1'b1;
            tick();
            pl_we  = 1'b0;
            prst_n = 1'b1;
            sen_n  = 1'b1;
            if (i == NB - 1 || i == NB - 2)
                check("R6 done timing", 64'(done), 64'(i == NB - 1));
        end
        check_regs("R5 serial order", v);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [NB-1:0] pat;
        logic [NB-1:0] pv;
        logic [W-1:0]  words [4];
        @(negedge clk);

        // R2 R9 R12: every preset code
        for (int c = 0; c < 5; c++) begin
            logic [W-1:0] e;
            master_reset(3'(c));
            tick();
            e = W'(c == 0 ? 8 : c == 1 ? 16 : c == 2 ? 64 : c == 3 ? 256 : 1024);
            check("R2 preset done", 64'(done), 64'd1);
            check_regs("R2 preset value", {4{e}});
            prst_n = 1'b0;
            sen_n = 1'b0;
            pl_we = 1'b1;
            tick();
            prst_n = 1'b1;
            sen_n = 1'b1;
            pl_we = 1'b0;
            check_regs("R9 prst preset", {4{e}});
            check("R9 done kept", 64'(done), 64'd1);
        end

        // R3 R4 R5 R6 R8 R10 R12: serial patterns under codes 6 and 7
        for (int p = 0; p < 4; p++) begin
            case (p)
                0: pat = {11'h7FF, 11'h000, 11'h555, 11'h2AA};
                1: pat = {11'd1, 11'd1024, 11'd37, 11'd2000};
                2: pat = {11'h123, 11'h456, 11'h789, 11'h0BC};
                default: pat = {4{11'h401}};
            endcase
            master_reset(p[0] ? 3'd7 : 3'd6);
            tick();
            check("R3 serial not done", 64'(done), 64'd0);
            serial_load(pat, p >= 2);
            for (int k = 0; k < 6; k++) begin
                sen_n = 1'b0;
                sdat = k[0];
                pl_we = 1'b1;
                tick();
            end
            sen_n = 1'b1;
            pl_we = 1'b0;
            check_regs("R8 extra bits", pat);
            check("R8 done held", 64'(done), 64'd1);
        end

        // R11: restart mid-way and check partial chain contents
        pat = {11'h3C3, 11'h0F0, 11'h5A5, 11'h1E1};
        master_reset(3'd6);
        tick();
        for (int i = 0; i < 20; i++) begin
            sen_n = 1'b0;
            sdat = pat[NB-1-i];
            tick();
        end
        sen_n = 1'b1;
        pv = NB'(pat >> (NB - 20));
        check("R11 partial not done", 64'(done), 64'd0);
        check_regs("R11 partial chain", pv);
        master_reset(3'd6);
        tick();
        serial_load(pat, 1'b0);

        // R3 R7 R8 R10: parallel loading with gaps and serial noise
        words[0] = 11'h00F;
        words[1] = 11'h7F0;
        words[2] = 11'h2C4;
        words[3] = 11'h013;
        master_reset(3'd5);
        tick();
        check("R3 parallel not done", 64'(done), 64'd0);
        for (int k = 0; k < 4; k++) begin
            pl_we = 1'b1;
            pl_data = words[k];
            sen_n = 1'b0;
            sdat = 1'b1;
            tick();
            pl_we = 1'b0;
            check("R7 done timing", 64'(done), 64'(k == 3));
            tick();
        end
        sen_n = 1'b1;
        check_regs("R7 parallel order", {words[0], words[1], words[2], words[3]});
        pl_we = 1'b1;
        pl_data = 11'h555;
        tick();
        pl_we = 1'b0;
        check_regs("R8 extra word", {words[0], words[1], words[2], words[3]});

        // R1: strap pins changing after release do not change the method
        master_reset(3'd0);
        strap_hi = 1'b1;
        sen_n = 1'b1;
        sdat = 1'b0;
        tick();
        check("R1 strap latched", 64'(done), 64'd1);
        check_regs("R1 strap latched", {4{11'd8}});

        finish_run();
    end

endmodule